// File: doc/BRIEF.md
# SPI with low-power retention

This block is an 8-bit serial peripheral port that can act as the clocking master or as a selected slave. Software reaches it through a small register bus with three registers. The data register loads the shift register when written and returns the last received frame when read. The control register holds the enable, the role, the interrupt enable, the wait-gating enable and the clock divisor. The status register holds the receive-full and busy bits. Frames are eight bits long, sent MSB first, with the clock idling low and data sampled on the rising edge.

The block also takes three low-power requests from the system. The first is a wait request, which takes effect only when the wait-gating bit is set. The second is a retained stop request. While either of these is in force, the bus side is treated as clock-gated. Register accesses are ignored and the receive-full flag cannot rise. A master transfer freezes in place. A slave keeps shifting and counting bits against the external clock. When a slave frame completes during such an episode, and the episode began while that frame was already in progress, the received byte is held back. On wake-up it is delivered to the data register together with the flag. A frame that lies entirely inside an idle-to-idle episode is dropped. The third request, non-retained stop, clears every register for as long as it is held.

Top module: `spi_lp`

## Requirements
- R1: After reset, reads of the data (address 0), control (address 1) and status (address 2) registers return 0. `irq` is 0, `ss_n_o` is 1 and `sck_o` is 0.
- R2: In master mode (control value: bit0 enable, bit1 master, bits 6:4 divisor field D), a write to the data register starts a frame. The frame has 8 rising edges on `sck_o`, with each SCK half-period lasting D+1 clock cycles. `mosi_o` carries the written byte MSB first and is valid at each rising edge. The byte sampled from `miso_i` is then readable from the data register, and status bit 7 (receive-full) is set.
- R3: In slave mode (bit1 clear), the block captures a frame from `mosi_i` MSB first on rising `sck_i` edges while `ss_n_i` is low. It sets the receive-full flag and shifts the byte last written to the data register out on `miso_o`, MSB first.
- R4: The receive-full flag clears only when a status read that sees it set is followed by a data read. A data read on its own leaves the flag set.
- R5: `irq` is high exactly while the receive-full flag is set and control bit2 (interrupt enable) is 1.
- R6: Suppose the bus side goes to sleep (wait request with control bit3 set) while a slave frame is in progress, and the frame finishes during the sleep. Then the flag and `irq` stay low until the sleep ends. At wake-up the received byte is copied into the data register and the flag is set.
- R7: A slave frame that starts and ends inside a sleep episode that was entered and left while idle produces no flag, and the data register keeps its previous contents.
- R8: A retained stop request puts the bus side to sleep whatever the value of control bit3. A wait request with bit3 clear has no effect: flags and register accesses work normally during it.
- R9: A master frame in progress when a retained stop begins holds `sck_o`, `mosi_o` and `ss_n_o` still. After the stop ends, the frame continues from the same bit and exchanges the correct bytes with exactly 8 rising SCK edges.
- R10: A slave frame that spans both the entry into and the exit from a retained stop stays bit-aligned with the external master. It completes with the correct byte and sets the flag normally.
- R11: While a non-retained stop request is held, any master frame is aborted (`ss_n_o` 1, `sck_o` 0). After the request is released, the control, status and data registers read 0 and `irq` is 0.
- R12: A slave frame run without a new write to the data register shifts out the shift register's current contents, which after a previous slave frame is that frame's received byte.
- R13: While the bus side sleeps, register writes have no effect and reads return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus-side clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Register access strobe, one cycle per access |
| bus_wr | input | 1 | 1 for a write, 0 for a read |
| bus_addr | input | 2 | Register select: 0 data, 1 control, 2 status |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data, valid while a read is strobed |
| wait_req | input | 1 | Wait request (gates only when control bit3 is set) |
| rstop_req | input | 1 | Retained-state stop request |
| nrstop_req | input | 1 | Non-retained stop request, clears all registers |
| sck_o | output | 1 | Serial clock driven in master mode |
| mosi_o | output | 1 | Master serial data out |
| ss_n_o | output | 1 | Active-low slave select driven in master mode |
| miso_i | input | 1 | Master serial data in |
| sck_i | input | 1 | Serial clock received in slave mode |
| mosi_i | input | 1 | Slave serial data in |
| ss_n_i | input | 1 | Active-low slave select received in slave mode |
| miso_o | output | 1 | Slave serial data out |
| irq | output | 1 | Receive interrupt |

## Verification
The bench aims at the edges of the sleep episodes. It enters sleep part-way through a slave frame and leaves it after the frame has ended; a design that did not defer would raise `irq` during sleep, and one that lost the frame would never raise it. It runs a whole frame inside an idle-to-idle sleep, where a design that always delivers would wrongly set the flag and overwrite the data. It freezes a master frame mid-byte, where a design that kept clocking or restarted would give extra SCK edges or corrupt bytes. It also exercises the status-then-data clearing order, the wait-gating bit in both states, the non-retained stop clear, and the shift-out of stale data in a slave frame that was never loaded.

// File: rtl/spi_lp_pkg.sv
`timescale 1ns/1ps
package spi_lp_pkg;
   localparam logic [1:0] ADDR_DATA = 2'd0;
   localparam logic [1:0] ADDR_CTRL = 2'd1;
   localparam logic [1:0] ADDR_STAT = 2'd2;
   localparam int DIV_W     = 3;
   localparam int STAT_RXF  = 7;
   localparam int STAT_BUSY = 0;

   typedef struct packed {
      logic             spare;
      logic [DIV_W-1:0] div;
      logic             lp_wait;
      logic             rie;
      logic             master;
      logic             en;
   } ctrl_t;
endpackage

// File: rtl/spi_lp_sync.sv
`timescale 1ns/1ps
module spi_lp_sync #(
   parameter int   STAGES  = 2,
   parameter logic RST_VAL = 1'b0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic q
);
   if (STAGES < 2) begin : g_bad_stages
      $error("spi_lp_sync: STAGES must be at least 2");
   end

   logic [STAGES-1:0] chain;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain <= {STAGES{RST_VAL}};
      else        chain <= {chain[STAGES-2:0], d};
   end

   assign q = chain[STAGES-1];
endmodule

// File: rtl/spi_lp_master.sv
`timescale 1ns/1ps
module spi_lp_master
   import spi_lp_pkg::*;
#(
   parameter int W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr,
   input  logic             en,
   input  logic             freeze,
   input  logic             start,
   input  logic [W-1:0]     ld_data,
   input  logic [DIV_W-1:0] div,
   input  logic             miso_i,
   output logic             sck_o,
   output logic             mosi_o,
   output logic             ss_n_o,
   output logic             busy,
   output logic             done,
   output logic [W-1:0]     rx
);
   localparam int CNT_W = $clog2(W);
   localparam logic [CNT_W-1:0] LAST = CNT_W'(W-1);

   logic [CNT_W-1:0] bitc;
   logic [DIV_W-1:0] divc;
   logic             sck;
   logic             rbit;
   logic [W-1:0]     sh;
   logic             go;
   logic             tick;

   assign go   = en && !clr && start && !busy && !freeze;
   assign tick = en && !clr && busy && !freeze && (divc == div);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy <= 1'b0;
         sck  <= 1'b0;
         bitc <= '0;
         divc <= '0;
         rbit <= 1'b0;
         done <= 1'b0;
         rx   <= '0;
      end else if (clr || !en) begin
         busy <= 1'b0;
         sck  <= 1'b0;
         bitc <= '0;
         divc <= '0;
         done <= 1'b0;
      end else begin
         done <= 1'b0;
         if (go) begin
            busy <= 1'b1;
            sck  <= 1'b0;
            bitc <= '0;
            divc <= '0;
         end else if (busy && !freeze) begin
            if (divc == div) begin
               divc <= '0;
               if (!sck) begin
                  sck  <= 1'b1;
                  rbit <= miso_i;
               end else begin
                  sck <= 1'b0;
                  if (bitc == LAST) begin
                     busy <= 1'b0;
                     done <= 1'b1;
                     rx   <= {sh[W-2:0], rbit};
                     bitc <= '0;
                  end else begin
                     bitc <= bitc + 1'b1;
                  end
               end
            end else begin
               divc <= divc + 1'b1;
            end
         end
      end
   end

   // Data path register: no reset, content after reset is undefined.
   always_ff @(posedge clk) begin
      if (go)              sh <= ld_data;
      else if (tick && sck) sh <= {sh[W-2:0], rbit};
   end

   assign sck_o  = sck;
   assign mosi_o = sh[W-1];
   assign ss_n_o = !busy;

   AST_FREEZE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && freeze && !clr) |=> ($stable(sck) && $stable(bitc) && busy)); // R9
   AST_START_CLEAN: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy) |-> (!sck && bitc == '0)); // R2
   AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (!busy && !sck)); // R2
endmodule

// File: rtl/spi_lp_slave.sv
`timescale 1ns/1ps
module spi_lp_slave #(
   parameter int W    = 8,
   parameter int SYNC = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         clr,
   input  logic         en,
   input  logic         load,
   input  logic [W-1:0] ld_data,
   input  logic         sck_i,
   input  logic         mosi_i,
   input  logic         ss_n_i,
   output logic         miso_o,
   output logic         busy,
   output logic         done,
   output logic [W-1:0] rx
);
   localparam int CNT_W = $clog2(W);
   localparam logic [CNT_W-1:0] LAST = CNT_W'(W-1);

   logic sck_s, mosi_s, ss_s;
   logic sck_q;
   logic rbit;
   logic rise, fall;
   logic [CNT_W-1:0] cnt;
   logic [W-1:0]     sh;

   spi_lp_sync #(.STAGES(SYNC), .RST_VAL(1'b0)) u_sync_sck (
      .clk(clk), .rst_n(rst_n), .d(sck_i), .q(sck_s));
   spi_lp_sync #(.STAGES(SYNC), .RST_VAL(1'b0)) u_sync_mosi (
      .clk(clk), .rst_n(rst_n), .d(mosi_i), .q(mosi_s));
   spi_lp_sync #(.STAGES(SYNC), .RST_VAL(1'b1)) u_sync_ss (
      .clk(clk), .rst_n(rst_n), .d(ss_n_i), .q(ss_s));

   assign rise = sck_s && !sck_q;
   assign fall = !sck_s && sck_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt   <= '0;
         sck_q <= 1'b0;
         rbit  <= 1'b0;
         done  <= 1'b0;
         rx    <= '0;
      end else if (clr) begin
         cnt   <= '0;
         sck_q <= 1'b0;
         rbit  <= 1'b0;
         done  <= 1'b0;
         rx    <= '0;
      end else begin
         done  <= 1'b0;
         sck_q <= sck_s;
         if (!en || ss_s) begin
            cnt <= '0;
         end else if (rise) begin
            rbit <= mosi_s;
            if (cnt == LAST) begin
               cnt  <= '0;
               done <= 1'b1;
               rx   <= {sh[W-2:0], mosi_s};
            end else begin
               cnt <= cnt + 1'b1;
            end
         end
      end
   end

   // Shift register keeps its content across reset on purpose.
   always_ff @(posedge clk) begin
      if (load)                            sh <= ld_data;
      else if (en && !ss_s && fall && !clr) sh <= {sh[W-2:0], rbit};
   end

   assign busy   = en && !ss_s;
   assign miso_o = busy ? sh[W-1] : 1'b0;

   AST_SLV_DESELECT_CNT: assert property (@(posedge clk) disable iff (!rst_n)
      ss_s |=> (cnt == '0)); // R10
   AST_SLV_DONE_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (cnt == '0)); // R3
endmodule

// File: rtl/spi_lp.sv
`timescale 1ns/1ps
module spi_lp
   import spi_lp_pkg::*;
#(
   parameter int DATA_W      = 8,
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_sel,
   input  logic              bus_wr,
   input  logic [1:0]        bus_addr,
   input  logic [DATA_W-1:0] bus_wdata,
   output logic [DATA_W-1:0] bus_rdata,
   input  logic              wait_req,
   input  logic              rstop_req,
   input  logic              nrstop_req,
   output logic              sck_o,
   output logic              mosi_o,
   output logic              ss_n_o,
   input  logic              miso_i,
   input  logic              sck_i,
   input  logic              mosi_i,
   input  logic              ss_n_i,
   output logic              miso_o,
   output logic              irq
);
   if (DATA_W < 8) begin : g_bad_width
      $error("spi_lp: DATA_W must be at least 8");
   end
   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("spi_lp: SYNC_STAGES must be at least 2");
   end

   ctrl_t             ctrl;
   logic              clr, asleep, awake, asleep_q;
   logic              wr_ev, rd_ev;
   logic              rxf, armed, pend, entry_busy;
   logic [DATA_W-1:0] rxbuf, pbuf;
   logic              mst_busy, mst_done, slv_busy, slv_done;
   logic [DATA_W-1:0] mst_rx, slv_rx;
   logic              mst_start, slv_load;
   logic [DATA_W-1:0] stat;

   assign clr    = nrstop_req;
   assign asleep = !clr && (rstop_req || (wait_req && ctrl.lp_wait));
   assign awake  = !clr && !asleep;
   assign wr_ev  = bus_sel && bus_wr && awake;
   assign rd_ev  = bus_sel && !bus_wr && awake;

   assign mst_start = wr_ev && (bus_addr == ADDR_DATA) && ctrl.master;
   assign slv_load  = wr_ev && (bus_addr == ADDR_DATA) && !ctrl.master;

   spi_lp_master #(.W(DATA_W)) u_master (
      .clk(clk), .rst_n(rst_n), .clr(clr),
      .en(ctrl.en && ctrl.master), .freeze(asleep),
      .start(mst_start), .ld_data(bus_wdata), .div(ctrl.div),
      .miso_i(miso_i), .sck_o(sck_o), .mosi_o(mosi_o), .ss_n_o(ss_n_o),
      .busy(mst_busy), .done(mst_done), .rx(mst_rx));

   spi_lp_slave #(.W(DATA_W), .SYNC(SYNC_STAGES)) u_slave (
      .clk(clk), .rst_n(rst_n), .clr(clr),
      .en(ctrl.en && !ctrl.master), .load(slv_load), .ld_data(bus_wdata),
      .sck_i(sck_i), .mosi_i(mosi_i), .ss_n_i(ss_n_i), .miso_o(miso_o),
      .busy(slv_busy), .done(slv_done), .rx(slv_rx));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctrl       <= '0;
         asleep_q   <= 1'b0;
         rxf        <= 1'b0;
         armed      <= 1'b0;
         pend       <= 1'b0;
         entry_busy <= 1'b0;
         rxbuf      <= '0;
         pbuf       <= '0;
      end else if (clr) begin
         ctrl       <= '0;
         asleep_q   <= 1'b0;
         rxf        <= 1'b0;
         armed      <= 1'b0;
         pend       <= 1'b0;
         entry_busy <= 1'b0;
         rxbuf      <= '0;
         pbuf       <= '0;
      end else begin
         asleep_q <= asleep;
         if (wr_ev && bus_addr == ADDR_CTRL) ctrl <= ctrl_t'(bus_wdata[7:0]);

         // Remember whether the sleep episode began inside a slave frame.
         if (!asleep)                 entry_busy <= 1'b0;
         else if (!asleep_q)          entry_busy <= slv_busy;
         else if (slv_done)           entry_busy <= 1'b0;

         if (asleep && slv_done && entry_busy && !pend) begin
            pend <= 1'b1;
            pbuf <= slv_rx;
         end

         if (rd_ev && bus_addr == ADDR_STAT && rxf) armed <= 1'b1;
         if (rd_ev && bus_addr == ADDR_DATA && armed) begin
            rxf   <= 1'b0;
            armed <= 1'b0;
         end

         if (!asleep && mst_done) begin
            rxbuf <= mst_rx;
            rxf   <= 1'b1;
         end else if (!asleep && slv_done) begin
            rxbuf <= slv_rx;
            rxf   <= 1'b1;
         end else if (!asleep && pend) begin
            rxbuf <= pbuf;
            rxf   <= 1'b1;
            pend  <= 1'b0;
         end
      end
   end

   always_comb begin
      stat            = '0;
      stat[STAT_RXF]  = rxf;
      stat[STAT_BUSY] = mst_busy || slv_busy;
   end

   always_comb begin
      bus_rdata = '0;
      if (rd_ev) begin
         case (bus_addr)
            ADDR_DATA: bus_rdata = rxbuf;
            ADDR_CTRL: bus_rdata = DATA_W'(ctrl);
            ADDR_STAT: bus_rdata = stat;
            default:   bus_rdata = '0;
         endcase
      end
   end

   assign irq = rxf && ctrl.rie;

   AST_NO_FLAG_ASLEEP: assert property (@(posedge clk) disable iff (!rst_n)
      (asleep && !rxf) |=> !rxf); // R6
   AST_PEND_DRAINS: assert property (@(posedge clk) disable iff (!rst_n)
      (awake && pend) |=> (!pend && rxf)); // R6
   AST_CTRL_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
      asleep |=> $stable(ctrl)); // R13
   AST_NRSTOP_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      nrstop_req |=> (ctrl == '0 && !rxf && rxbuf == '0 && !pend)); // R11
endmodule

// File: tb/sim_spi_lp.sv
`timescale 1ns/1ps
module sim_spi_lp;
   localparam int HALF = 8;
   localparam logic [1:0] A_DATA = 2'd0, A_CTRL = 2'd1, A_STAT = 2'd2;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       bus_sel = 1'b0, bus_wr = 1'b0;
   logic [1:0] bus_addr = 2'd0;
   logic [7:0] bus_wdata = 8'h00;
   logic [7:0] bus_rdata;
   logic       wait_req = 1'b0, rstop_req = 1'b0, nrstop_req = 1'b0;
   logic       sck_o, mosi_o, ss_n_o, miso_i;
   logic       sck_i = 1'b0, mosi_i = 1'b0, ss_n_i = 1'b1;
   logic       miso_o, irq;

   int errors = 0;
   int checks = 0;
   bit finished = 0;

   logic [7:0] tb_miso_reg = 8'h00;
   logic [7:0] mosi_cap = 8'h00;
   logic [7:0] cap_miso = 8'h00;
   int sck_rises = 0;
   int sck_high = 0;

   always #2.5 clk = ~clk;

   spi_lp u0 (
      .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .wait_req(wait_req), .rstop_req(rstop_req), .nrstop_req(nrstop_req),
      .sck_o(sck_o), .mosi_o(mosi_o), .ss_n_o(ss_n_o), .miso_i(miso_i),
      .sck_i(sck_i), .mosi_i(mosi_i), .ss_n_i(ss_n_i), .miso_o(miso_o),
      .irq(irq));

   // Bench-side slave used when the design is master.
   assign miso_i = tb_miso_reg[7];
   always @(posedge sck_o) begin
      mosi_cap = {mosi_cap[6:0], mosi_o};
      sck_rises++;
   end
   always @(negedge sck_o) tb_miso_reg = {tb_miso_reg[6:0], 1'b0};
   always @(negedge clk) if (sck_o === 1'b1) sck_high++;

   task automatic tick(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic bus_write(input logic [1:0] a, input logic [7:0] d);
      bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
      @(negedge clk);
      bus_sel = 1'b0; bus_wr = 1'b0;
   endtask

   task automatic bus_read(input logic [1:0] a, output logic [7:0] d);
      bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
      #1 d = bus_rdata;
      @(negedge clk);
      bus_sel = 1'b0;
   endtask

   task automatic clear_flag();
      logic [7:0] v;
      bus_read(A_STAT, v);
      bus_read(A_DATA, v);
   endtask

   task automatic wait_mst_done();
      int n = 0;
      while (ss_n_o !== 1'b1 && n < 2000) begin tick(1); n++; end
      tick(3);
   endtask

   task automatic ss_lo();
      ss_n_i = 1'b0; tick(HALF);
   endtask

   task automatic ss_hi();
      tick(HALF); ss_n_i = 1'b1; tick(HALF);
   endtask

   task automatic sbits(input logic [7:0] b, input int first, input int last);
      for (int i = first; i <= last; i++) begin
         mosi_i = b[7-i];
         tick(HALF);
         sck_i = 1'b1;
         cap_miso = {cap_miso[6:0], miso_o};
         tick(HALF);
         sck_i = 1'b0;
      end
   endtask

   task automatic slave_frame(input logic [7:0] b);
      ss_lo(); sbits(b, 0, 7); ss_hi();
   endtask

   task automatic t_reset();
      logic [7:0] v;
      bus_read(A_DATA, v); chk("R1 data after reset", v, 8'h00);
      bus_read(A_CTRL, v); chk("R1 ctrl after reset", v, 8'h00);
      bus_read(A_STAT, v); chk("R1 status after reset", v, 8'h00);
      chk("R1 irq", irq, 1'b0);
      chk("R1 ss_n_o", ss_n_o, 1'b1);
      chk("R1 sck_o", sck_o, 1'b0);
   endtask

   task automatic t_master_basic();
      logic [7:0] v;
      bus_write(A_CTRL, 8'h27);          // en, master, rie, D=2
      tb_miso_reg = 8'hA5; sck_rises = 0; sck_high = 0;
      bus_write(A_DATA, 8'h3C);
      wait_mst_done();
      chk("R2 mosi byte", mosi_cap, 8'h3C);
      chk("R2 sck rising edges", sck_rises, 8);
      chk("R2 sck high cycles D=2", sck_high, 24);
      chk("R5 irq with rie", irq, 1'b1);
      bus_read(A_STAT, v); chk("R2 status rxf", v, 8'h80);
      bus_read(A_DATA, v); chk("R2 received byte", v, 8'hA5);
      chk("R4 cleared after status+data", irq, 1'b0);
   endtask

   task automatic t_master_order();
      logic [7:0] v;
      bus_write(A_CTRL, 8'h03);          // en, master, no rie, D=0
      tb_miso_reg = 8'h5A; sck_rises = 0; sck_high = 0;
      bus_write(A_DATA, 8'h81);
      wait_mst_done();
      chk("R5 irq masked", irq, 1'b0);
      chk("R2 sck high cycles D=0", sck_high, 8);
      chk("R2 mosi byte D=0", mosi_cap, 8'h81);
      bus_read(A_DATA, v); chk("R2 received byte D=0", v, 8'h5A);
      bus_read(A_STAT, v); chk("R4 data read alone keeps flag", v, 8'h80);
      bus_read(A_DATA, v);
      bus_read(A_STAT, v); chk("R4 flag cleared", v, 8'h00);
   endtask

   task automatic t_slave();
      logic [7:0] v;
      bus_write(A_CTRL, 8'h05);          // en, slave, rie
      bus_write(A_DATA, 8'hC3);
      slave_frame(8'h96);
      chk("R3 miso byte", cap_miso, 8'hC3);
      chk("R3 irq", irq, 1'b1);
      bus_read(A_STAT, v); chk("R3 status rxf", v, 8'h80);
      bus_read(A_DATA, v); chk("R3 received byte", v, 8'h96);
   endtask

   task automatic t_noload();
      logic [7:0] v;
      slave_frame(8'h11);
      chk("R12 stale shift-out", cap_miso, 8'h96);
      bus_read(A_STAT, v);
      bus_read(A_DATA, v); chk("R12 received byte", v, 8'h11);
   endtask

   task automatic t_wait_mid();
      logic [7:0] v;
      bus_write(A_CTRL, 8'h0D);          // en, slave, rie, wait gating
      ss_lo();
      sbits(8'h6B, 0, 2);
      wait_req = 1'b1;
      sbits(8'h6B, 3, 7);
      ss_hi();
      chk("R6 irq held during sleep", irq, 1'b0);
      bus_read(A_STAT, v); chk("R13 read during sleep", v, 8'h00);
      wait_req = 1'b0;
      tick(3);
      chk("R6 irq after wake", irq, 1'b1);
      bus_read(A_STAT, v); chk("R6 status after wake", v, 8'h80);
      bus_read(A_DATA, v); chk("R6 deferred byte", v, 8'h6B);
   endtask

   task automatic t_idle_sleep();
      logic [7:0] v;
      wait_req = 1'b1;
      tick(4);
      slave_frame(8'h44);
      wait_req = 1'b0;
      tick(5);
      chk("R7 no irq", irq, 1'b0);
      bus_read(A_STAT, v); chk("R7 no flag", v, 8'h00);
      bus_read(A_DATA, v); chk("R7 data kept", v, 8'h6B);
   endtask

   task automatic t_rstop_slave();
      logic [7:0] v;
      bus_write(A_CTRL, 8'h05);          // wait gating off
      ss_lo();
      sbits(8'hE7, 0, 1);
      rstop_req = 1'b1;
      bus_write(A_CTRL, 8'h00);          // must be ignored
      sbits(8'hE7, 2, 4);
      chk("R8 rstop gates despite bit3=0", irq, 1'b0);
      rstop_req = 1'b0;
      sbits(8'hE7, 5, 7);
      ss_hi();
      chk("R10 irq after frame", irq, 1'b1);
      bus_read(A_CTRL, v); chk("R13 ctrl write ignored", v, 8'h05);
      bus_read(A_STAT, v);
      bus_read(A_DATA, v); chk("R10 aligned byte", v, 8'hE7);
   endtask

   task automatic t_wait_noen();
      logic [7:0] v;
      wait_req = 1'b1;
      tick(2);
      slave_frame(8'h29);
      chk("R8 irq during ungated wait", irq, 1'b1);
      bus_read(A_STAT, v); chk("R8 status during wait", v, 8'h80);
      bus_read(A_DATA, v); chk("R8 data during wait", v, 8'h29);
      wait_req = 1'b0;
      tick(2);
   endtask

   task automatic t_master_freeze();
      logic [7:0] v;
      logic s0, m0, n0;
      bit bad = 0;
      int r0, n = 0;
      bus_write(A_CTRL, 8'h37);          // en, master, rie, D=3
      tb_miso_reg = 8'hD2; sck_rises = 0;
      bus_write(A_DATA, 8'h4E);
      while (sck_rises < 3 && n < 500) begin tick(1); n++; end
      tick(2);
      rstop_req = 1'b1;
      s0 = sck_o; m0 = mosi_o; n0 = ss_n_o; r0 = sck_rises;
      for (int i = 0; i < 40; i++) begin
         tick(1);
         if (sck_o !== s0 || mosi_o !== m0 || ss_n_o !== n0) bad = 1;
      end
      chk("R9 pins frozen", bad, 0);
      chk("R9 no edges while frozen", sck_rises, r0);
      rstop_req = 1'b0;
      wait_mst_done();
      chk("R9 rising edges total", sck_rises, 8);
      chk("R9 mosi byte", mosi_cap, 8'h4E);
      bus_read(A_STAT, v);
      bus_read(A_DATA, v); chk("R9 received byte", v, 8'hD2);
   endtask

   task automatic t_nrstop();
      logic [7:0] v;
      bus_write(A_DATA, 8'h99);
      tick(10);
      nrstop_req = 1'b1;
      tick(2);
      chk("R11 ss_n_o released", ss_n_o, 1'b1);
      chk("R11 sck_o low", sck_o, 1'b0);
      nrstop_req = 1'b0;
      tick(2);
      bus_read(A_CTRL, v); chk("R11 ctrl cleared", v, 8'h00);
      bus_read(A_STAT, v); chk("R11 status cleared", v, 8'h00);
      bus_read(A_DATA, v); chk("R11 data cleared", v, 8'h00);
      chk("R11 irq low", irq, 1'b0);
   endtask

   initial begin
      tick(4);
      rst_n = 1'b1;
      tick(2);
      t_reset();
      t_master_basic();
      t_master_order();
      t_slave();
      t_noload();
      t_wait_mid();
      t_idle_sleep();
      t_rstop_slave();
      t_wait_noen();
      t_master_freeze();
      bus_read(A_CTRL, bus_wdata);
      t_nrstop();
      if (!finished) begin
         finished = 1;
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!finished) begin
         finished = 1;
         checks++;
         errors++;
         $display("FAIL watchdog: actual=timeout expected=completion");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end
endmodule